// File: doc/BRIEF.md
# I2S to Simultaneous-Mode DAC Formatter

This block takes a standard I2S stream and turns it into the simultaneous format that some multibit DACs need. The DAC receives the left and right words on two separate serial lines at the same moment. It also receives a bit clock that runs only while a word is loaded, and a latch strobe that moves the loaded pair into its output latches. Each input frame lasts 64 bit periods, and the falling edge of word select marks its start. From that frame the block keeps only the first 16 data bits of each half. It sends both words out together in a burst of 16 clock pulses during the following frame. The latch strobe is issued at the next falling edge of word select, so the sample period of the input is carried over unchanged.

The block runs on one core clock at twice the bit rate. The I2S lines are generated synchronously to this clock, so the input bit clock toggles on every core cycle. The burst is sequenced by a four-state machine:
- HUNT waits for the first complete frame.
- WAIT counts bit periods after a frame start.
- SHIFT sends the 16 bits.
- HOLD waits for the next frame start.

The transitions are as follows:
- HUNT goes to WAIT on a frame start that ends a complete frame.
- WAIT goes to SHIFT when the bit-period count reaches the programmed start offset.
- SHIFT goes to HOLD after the sixteenth bit.
- HOLD goes to WAIT at the next frame start, and that is when the strobe fires.

Four static selects adapt the output to the target DAC family:
- MSB inversion.
- Strobe edge.
- Clock phase.
- Burst start offset.

Top module: `i2s_simul_formatter`

## Requirements
- R1: A bit period is counted on each rising edge of the input bit clock, and a frame starts at the rising edge where word select is first seen low after being high. In each half of the frame, the bits at the 1st to 16th rising edges after the word-select change form that channel's word, MSB first (low half = left, high half = right). Every other bit position is ignored.
- R2: After reset no clock pulse, strobe or data bit is emitted until a complete frame has been received. The first frame start seen after reset begins that complete frame, and its words go out in the frame that follows it.
- R3: The words received in frame N are shifted out in frame N+1. Left goes on `dac_dl` and right on `dac_dr`, both MSB first and at the same time. Each bit lasts one bit period (two core clocks).
- R4: `dac_bck` makes exactly 16 pulses per frame, one per burst bit, and stays at its idle level at all other times.
- R5: The strobe is active for exactly one bit period (two core clocks). It starts on the core clock after the frame-start edge, and only when a full burst was sent in the frame before, so it fires once per frame.
- R6: With `cfg_msb_inv` = 1, the first (MSB) bit of both output words is inverted. The other 15 bits are never inverted, and with `cfg_msb_inv` = 0 the MSB passes unchanged.
- R7: With `cfg_le_fall` = 0, `dac_le` idles low and pulses high, so the DAC latches on the rising edge. With `cfg_le_fall` = 1, it idles high and pulses low, so the DAC latches on the falling edge.
- R8: With `cfg_bck_inv` = 0, `dac_bck` is low in the first core clock of each bit and high in the second. The data changes while the clock is low and is stable at the rising edge. With `cfg_bck_inv` = 1 the clock is inverted, idle level included.
- R9: The first burst bit is placed in the bit period numbered `cfg_ofs` (1 to 47), where the frame-start bit period is number 0. All 16 bits therefore fit before the next frame start.
- R10: Outside the burst, `dac_dl` and `dac_dr` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the I2S bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_bck | input | 1 | I2S bit clock, toggling every core cycle |
| i2s_ws | input | 1 | I2S word select, low = left |
| i2s_sd | input | 1 | I2S serial data |
| cfg_ofs | input | 6 | Burst start bit period after frame start (1..47) |
| cfg_msb_inv | input | 1 | Invert the MSB of each output word |
| cfg_le_fall | input | 1 | Strobe polarity: 1 = active-low pulse |
| cfg_bck_inv | input | 1 | Invert the output bit clock |
| dac_dl | output | 1 | Left serial data to the DAC |
| dac_dr | output | 1 | Right serial data to the DAC |
| dac_bck | output | 1 | Gated bit clock to the DAC |
| dac_le | output | 1 | Latch strobe to the DAC |

## Verification
Every result is due one core clock after the input bit-clock rising edge that causes it. The second half of a burst bit appears one further core clock later. A strobe or burst comes one frame after the words it carries were received.

The bench drives inputs and samples outputs on falling core-clock edges. It compares the value seen at each falling edge with the behavioural model's value for the half-bit produced by the previous rising edge. Each half-bit is therefore checked exactly once, in the cycle it becomes visible. The bench also reassembles every burst word and checks the bit period in which each burst starts.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [1:0] {
        S_HUNT,
        S_WAIT,
        S_SHIFT,
        S_HOLD
    } burst_st_t;

endpackage

// File: rtl/fmt_capture.sv
module fmt_capture #(
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 64,
    localparam int SLOT_W     = $clog2(FRAME_SLOTS),
    localparam int HALF       = FRAME_SLOTS / 2,
    localparam int IDX_W      = $clog2(HALF) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i2s_bck,
    input  logic              i2s_ws,
    input  logic              i2s_sd,
    output logic              bit_tick,
    output logic              frame_edge,
    output logic              frame_ok,
    output logic [SLOT_W-1:0] slot_now,
    output logic [WORD_W-1:0] word_l,
    output logic [WORD_W-1:0] word_r
);

    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic              bck_q;
    logic              ws_last;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_eff;
    logic [SLOT_W-1:0] slot_q;
    logic              seen_fall;
    logic              seen_rise;
    logic              ws_flip;
    logic              take;
    logic [1:0][WORD_W-1:0] sr_q;

    assign bit_tick   = i2s_bck & ~bck_q;
    assign ws_flip    = i2s_ws ^ ws_last;
    assign frame_edge = bit_tick & ws_flip & ~i2s_ws;
    assign frame_ok   = frame_edge & seen_rise;
    assign slot_now   = frame_edge ? '0 : slot_q + 1'b1;

    always_comb begin
        if (ws_flip)
            idx_eff = '0;
        else if (idx_q == IDX_MAX)
            idx_eff = idx_q;
        else
            idx_eff = idx_q + 1'b1;
    end

    assign take = bit_tick && (idx_eff >= IDX_W'(1)) && (idx_eff <= IDX_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_q     <= 1'b0;
            ws_last   <= 1'b0;
            idx_q     <= '0;
            slot_q    <= '0;
            seen_fall <= 1'b0;
            seen_rise <= 1'b0;
        end else begin
            bck_q <= i2s_bck;
            if (bit_tick) begin
                ws_last <= i2s_ws;
                idx_q   <= idx_eff;
                slot_q  <= slot_now;
                if (frame_edge)
                    seen_fall <= 1'b1;
                if (ws_flip && i2s_ws && seen_fall)
                    seen_rise <= 1'b1;
            end
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n)
                sr_q[c] <= '0;
            else if (take && (i2s_ws == c[0]))
                sr_q[c] <= {sr_q[c][WORD_W-2:0], i2s_sd};
        end
    end

    assign word_l = sr_q[0];
    assign word_r = sr_q[1];

    // R1: once framing is known, every frame spans exactly FRAME_SLOTS bit periods
    p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && seen_fall) |-> (slot_q == SLOT_W'(FRAME_SLOTS - 1)));

endmodule

// File: rtl/fmt_burst.sv
module fmt_burst
    import fmt_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int SLOT_W  = 6,
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_edge,
    input  logic              frame_ok,
    input  logic [SLOT_W-1:0] slot_now,
    input  logic [WORD_W-1:0] word_l,
    input  logic [WORD_W-1:0] word_r,
    input  logic [SLOT_W-1:0] cfg_ofs,
    input  logic              cfg_msb_inv,
    output logic              dl_q,
    output logic              dr_q,
    output logic              half_q,
    output logic              le_q
);

    burst_st_t         st, st_n;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] sh_l, sh_r;
    logic              first_bit;

    assign first_bit = (st == S_WAIT);

    // next-state logic
    always_comb begin
        st_n = st;
        if (bit_tick) begin
            if (frame_edge) begin
                st_n = frame_ok ? S_WAIT : S_HUNT;
            end else begin
                unique case (st)
                    S_HUNT:  st_n = S_HUNT;
                    S_WAIT:  if (slot_now == cfg_ofs) st_n = S_SHIFT;
                    S_SHIFT: if (bit_q == BIT_W'(WORD_W - 1)) st_n = S_HOLD;
                    S_HOLD:  st_n = S_HOLD;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_HUNT;
        else
            st <= st_n;
    end

    // outputs and word buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q   <= 1'b0;
            dr_q   <= 1'b0;
            half_q <= 1'b0;
            le_q   <= 1'b0;
            bit_q  <= '0;
            sh_l   <= '0;
            sh_r   <= '0;
        end else if (bit_tick) begin
            le_q   <= frame_edge && (st == S_HOLD);
            half_q <= 1'b0;
            if (frame_edge && frame_ok) begin
                sh_l <= word_l;
                sh_r <= word_r;
            end else if (st_n == S_SHIFT) begin
                sh_l <= {sh_l[WORD_W-2:0], 1'b0};
                sh_r <= {sh_r[WORD_W-2:0], 1'b0};
            end
            if (st_n == S_SHIFT) begin
                dl_q <= sh_l[WORD_W-1] ^ (first_bit & cfg_msb_inv);
                dr_q <= sh_r[WORD_W-1] ^ (first_bit & cfg_msb_inv);
            end else begin
                dl_q <= 1'b0;
                dr_q <= 1'b0;
            end
            bit_q <= (st == S_SHIFT) ? bit_q + 1'b1 : '0;
        end else begin
            half_q <= (st == S_SHIFT);
        end
    end

    // checker state: clock pulses seen since the last strobe
    logic       half_d;
    logic [5:0] pulses;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_d <= 1'b0;
            pulses <= '0;
        end else begin
            half_d <= half_q;
            if (le_q)
                pulses <= '0;
            else if (half_q && !half_d)
                pulses <= pulses + 1'b1;
        end
    end

    // R4 / R5: a strobe follows a complete burst of WORD_W pulses
    p_burst_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le_q) |-> (pulses == 6'(WORD_W)));

    // R5: the strobe is two core clocks wide
    p_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(le_q) |=> le_q);
    p_strobe_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (le_q && $past(le_q)) |=> !le_q);

    // R8: data is stable across the clock's active edge
    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_q) |-> ($stable(dl_q) && $stable(dr_q)));

    // R2: nothing leaves the block before a complete frame
    p_hunt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HUNT) |-> (!half_q && !le_q && !dl_q && !dr_q));

endmodule

// File: rtl/i2s_simul_formatter.sv
module i2s_simul_formatter #(
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 64,
    localparam int SLOT_W     = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i2s_bck,
    input  logic              i2s_ws,
    input  logic              i2s_sd,
    input  logic [SLOT_W-1:0] cfg_ofs,
    input  logic              cfg_msb_inv,
    input  logic              cfg_le_fall,
    input  logic              cfg_bck_inv,
    output logic              dac_dl,
    output logic              dac_dr,
    output logic              dac_bck,
    output logic              dac_le
);

    logic              bit_tick;
    logic              frame_edge;
    logic              frame_ok;
    logic [SLOT_W-1:0] slot_now;
    logic [WORD_W-1:0] word_l, word_r;
    logic              half_q, le_q;

    fmt_capture #(
        .WORD_W      (WORD_W),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .i2s_bck    (i2s_bck),
        .i2s_ws     (i2s_ws),
        .i2s_sd     (i2s_sd),
        .bit_tick   (bit_tick),
        .frame_edge (frame_edge),
        .frame_ok   (frame_ok),
        .slot_now   (slot_now),
        .word_l     (word_l),
        .word_r     (word_r)
    );

    fmt_burst #(
        .WORD_W (WORD_W),
        .SLOT_W (SLOT_W)
    ) i_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .frame_edge  (frame_edge),
        .frame_ok    (frame_ok),
        .slot_now    (slot_now),
        .word_l      (word_l),
        .word_r      (word_r),
        .cfg_ofs     (cfg_ofs),
        .cfg_msb_inv (cfg_msb_inv),
        .dl_q        (dac_dl),
        .dr_q        (dac_dr),
        .half_q      (half_q),
        .le_q        (le_q)
    );

    assign dac_bck = half_q ^ cfg_bck_inv;
    assign dac_le  = le_q ^ cfg_le_fall;

endmodule

// File: tb/test_i2s_simul_formatter.sv
module test_i2s_simul_formatter;

    localparam int CLK_PERIOD = 10;
    localparam int NF         = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i2s_bck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
    logic [5:0] cfg_ofs = 6'd5;
    logic       cfg_msb_inv = 1'b0, cfg_le_fall = 1'b0, cfg_bck_inv = 1'b0;
    logic       dac_dl, dac_dr, dac_bck, dac_le;

    i2s_simul_formatter i_i2s_simul_formatter (
        .clk(clk), .rst_n(rst_n), .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
        .cfg_ofs(cfg_ofs), .cfg_msb_inv(cfg_msb_inv), .cfg_le_fall(cfg_le_fall),
        .cfg_bck_inv(cfg_bck_inv), .dac_dl(dac_dl), .dac_dr(dac_dr),
        .dac_bck(dac_bck), .dac_le(dac_le)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [15:0] wl [NF];
    logic [15:0] wr [NF];
    int pf, pk;
    int cur_ofs;
    logic [15:0] asm_l, asm_r;
    bit prev_act;

    task automatic check(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b (frame %0d bit %0d)", tag, name, act, exp, pf, pk);
        end
    endtask

    // reference: state of the outputs for half-bit ph of bit period (f,k)
    task automatic compare(bit ph);
        bit burst, strobe, act;
        int i;
        logic edl, edr, ebck, ele;
        string dtag, ctag;
        burst  = (pf >= 2) && (pk >= cur_ofs) && (pk < cur_ofs + 16);
        strobe = (pf >= 3) && (pk == 0);
        i = pk - cur_ofs;
        edl = burst ? (wl[pf-1][15-i] ^ ((i == 0) & cfg_msb_inv)) : 1'b0;
        edr = burst ? (wr[pf-1][15-i] ^ ((i == 0) & cfg_msb_inv)) : 1'b0;
        ebck = (burst && ph) ^ cfg_bck_inv;
        ele  = strobe ^ cfg_le_fall;
        dtag = (pf < 2) ? "R2" : (burst ? ((i == 0) ? "R6" : "R3") : "R10");
        ctag = (pf < 2) ? "R2" : (burst ? "R8" : "R4");
        check(dtag, "dac_dl", dac_dl, edl);
        check(dtag, "dac_dr", dac_dr, edr);
        check(ctag, "dac_bck", dac_bck, ebck);
        check(strobe ? "R5" : "R7", "dac_le", dac_le, ele);
        if (ph) begin
            act = (dac_bck !== cfg_bck_inv);
            if (act && !prev_act && pf >= 0) begin
                // R9: burst begins at the programmed bit period
                check("R9", "burst start", (pk == cur_ofs), 1'b1);
            end
            prev_act = act;
            if (burst) begin
                asm_l = {asm_l[14:0], dac_dl ^ ((i == 0) & cfg_msb_inv)};
                asm_r = {asm_r[14:0], dac_dr ^ ((i == 0) & cfg_msb_inv)};
                if (i == 15) begin
                    // R1: only bits 1..16 after each word-select change make up the words
                    checks++;
                    if (asm_l !== wl[pf-1] || asm_r !== wr[pf-1]) begin
                        errors++;
                        $display("FAIL R1 words: got %h/%h expected %h/%h", asm_l, asm_r, wl[pf-1], wr[pf-1]);
                    end
                end
            end
        end
    endtask

    task automatic drive_slot(int f, int k);
        @(negedge clk);
        compare(1'b0);
        i2s_bck = 1'b0;
        i2s_ws  = (k >= 32);
        if (k >= 1 && k <= 16)       i2s_sd = wl[f][16-k];
        else if (k >= 33 && k <= 48) i2s_sd = wr[f][48-k];
        else                         i2s_sd = $urandom_range(0, 1);
        @(negedge clk);
        compare(1'b1);
        i2s_bck = 1'b1;
        pf = f;
        pk = k;
    endtask

    task automatic run(int ofs, bit inv, bit lef, bit bi, bit corner);
        cur_ofs = ofs;
        cfg_ofs = 6'(ofs);
        cfg_msb_inv = inv;
        cfg_le_fall = lef;
        cfg_bck_inv = bi;
        rst_n = 1'b0;
        i2s_bck = 1'b0; i2s_ws = 1'b0; i2s_sd = 1'b0;
        pf = -9; pk = 0; prev_act = 1'b0;
        for (int f = 0; f < NF; f++) begin
            wl[f] = 16'($urandom);
            wr[f] = 16'($urandom);
        end
        if (corner) begin
            wl[1] = 16'h8000; wr[1] = 16'h7FFF;
            wl[2] = 16'h0000; wr[2] = 16'hFFFF;
            wl[3] = 16'h0001; wr[3] = 16'hA5A5;
        end
        repeat (3) @(negedge clk);
        compare(1'b0); // reset state (R2, R7, R8 idle levels)
        rst_n = 1'b1;
        for (int f = 0; f < NF; f++)
            for (int k = 0; k < 64; k++)
                drive_slot(f, k);
        @(negedge clk);
        compare(1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run(5,  1'b0, 1'b0, 1'b0, 1'b1);
        run(24, 1'b1, 1'b1, 1'b0, 1'b1);
        run(47, 1'b0, 1'b1, 1'b1, 1'b0);
        run(1,  1'b1, 1'b0, 1'b1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule